// File: doc/BRIEF.md
# Configurable Loop and Instruction-Squash Fetch Unit

This block is the front end of a small decoder processor. It walks a program memory one word per cycle and hands each word to later pipeline stages through a registered issue port. One common program drives every operating mode. The block makes that possible in two ways. First, a repeat instruction takes its pass count indirectly from one of two configuration values, chosen by an operand. Second, a fixed address window that holds the tail-bit work is turned into no-operation words whenever the tail flag is clear.

The unit also recognises an initialization instruction, which it flags with a one-cycle strobe, and a stop instruction, which parks the unit. A restart pulse resumes fetching at the head of the frame loop. The initialization section is not run again, so the same configuration can decode frame after frame.

The controller has two states. RUN issues one word per cycle. HALT issues nothing. Reset enters RUN at address 0. RUN moves to HALT in the cycle that issues a stop word. HALT moves back to RUN when restart is sampled high, and the program counter is set to the resume address.

Top module: `loop_fetch_unit`

## Requirements
- R1: While reset is held, `iss_valid` and `halted` are low. The first word issued after reset comes from address 0.
- R2: In RUN, one word is issued on every clock edge. `iss_instr` equals the memory word at `iss_addr`, and the next address is the previous address plus one unless a loop jump applies.
- R3: A repeat word has opcode 4'h1 in bits [15:12], the count selector in bit 8 and the loop end address in bits [7:0]. With selector 0, the body (the repeat address plus one, through the end address) runs `cfg_size` times.
- R4: With selector 1, the repeat body runs `cfg_iter` times.
- R5: A selected count of zero runs the body exactly once.
- R6: Jumping back from the end address to the body start, and leaving the loop after the last pass, add no idle cycle to the issue stream.
- R7: With `tail_en` low, every word fetched from addresses TAIL_LO to TAIL_HI (default 4 to 15) is issued as all-zero (no-operation). Its address and cycle are unchanged, and the replaced word has no control effect.
- R8: With `tail_en` high, words in the tail window are issued unchanged.
- R9: `init_strobe` is high exactly in the cycles where the issued word has opcode 4'h2.
- R10: A word with opcode 4'h3 is issued and `halted` rises in the same cycle. After that, nothing is issued until a restart.
- R11: A restart pulse sampled in HALT makes the next issued word, one edge later, come from RESUME_ADDR (default 16). A restart pulse seen in RUN has no effect on the issue stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tail_en | input | 1 | Tail-bit work enabled for this processor |
| cfg_size | input | CW | Pass count used by selector 0 |
| cfg_iter | input | CW | Pass count used by selector 1 |
| restart | input | 1 | Resume pulse, used only in HALT |
| pm_addr | output | AW | Program memory read address |
| pm_data | input | IW | Program memory word at `pm_addr`, same cycle |
| iss_valid | output | 1 | Issue port holds a word |
| iss_addr | output | AW | Address of the issued word |
| iss_instr | output | IW | Issued word, after tail replacement |
| init_strobe | output | 1 | Issued word is an initialization instruction |
| halted | output | 1 | Controller is in HALT |

## Verification
A wrong loop count or jump target shows at the issue port on the edge after the loop end word, as an address that breaks the expected series. A lost or stuck loop-active flag shows up either as an extra pass or as an early fall-through. A tail window decoded one address off shows a nonzero word, or a zero where a word was expected, at the window edges in the cycle that word is issued. A controller stuck in the wrong state shows up either as an issue after a stop word, or as a missing issue one edge after restart.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
    localparam logic [3:0] OPC_NOP    = 4'h0;
    localparam logic [3:0] OPC_REPEAT = 4'h1;
    localparam logic [3:0] OPC_INIT   = 4'h2;
    localparam logic [3:0] OPC_STOP   = 4'h3;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } lfu_state_e;
endpackage

// File: rtl/lfu_decode.sv
module lfu_decode #(
    parameter int IW      = 16,
    parameter int AW      = 8,
    parameter int TAIL_LO = 4,
    parameter int TAIL_HI = 15
) (
    input  logic [AW-1:0] pc,
    input  logic [IW-1:0] word,
    input  logic          tail_en,
    output logic [IW-1:0] eff_word,
    output logic          is_rep,
    output logic          is_init,
    output logic          is_stop,
    output logic          rep_sel,
    output logic [AW-1:0] rep_end
);
    import lfu_pkg::*;

    localparam logic [AW-1:0] WIN_LO = AW'(TAIL_LO);
    localparam logic [AW-1:0] WIN_HI = AW'(TAIL_HI);

    logic       in_window;
    logic [3:0] opc;

    // Tail window is replaced before decode so a replaced word has no effect
    assign in_window = (pc >= WIN_LO) && (pc <= WIN_HI);
    assign eff_word  = (in_window && !tail_en) ? '0 : word;
    assign opc       = eff_word[IW-1 -: 4];

    assign is_rep  = (opc == OPC_REPEAT);
    assign is_init = (opc == OPC_INIT);
    assign is_stop = (opc == OPC_STOP);
    assign rep_sel = eff_word[AW];
    assign rep_end = eff_word[AW-1:0];
endmodule

// File: rtl/lfu_loop.sv
module lfu_loop #(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [AW-1:0] pc,
    input  logic          load,
    input  logic          sel,
    input  logic [AW-1:0] end_addr,
    input  logic [CW-1:0] cfg_size,
    input  logic [CW-1:0] cfg_iter,
    output logic          jump,
    output logic [AW-1:0] target
);
    logic          active_q;
    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] src_cnt;
    logic [CW-1:0] first_cnt;
    logic          at_end;

    assign src_cnt   = sel ? cfg_iter : cfg_size;
    assign first_cnt = (src_cnt == '0) ? CW'(1) : src_cnt;
    assign at_end    = active_q && (pc == end_q);
    assign jump      = at_end && (cnt_q > CW'(1));
    assign target    = start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            start_q  <= '0;
            end_q    <= '0;
            cnt_q    <= '0;
        end else if (clear) begin
            active_q <= 1'b0;
        end else if (advance) begin
            if (load) begin
                active_q <= 1'b1;
                start_q  <= pc + AW'(1);
                end_q    <= end_addr;
                cnt_q    <= first_cnt;
            end else if (at_end) begin
                if (cnt_q > CW'(1)) cnt_q <= cnt_q - CW'(1);
                else                active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/loop_fetch_unit.sv
module loop_fetch_unit #(
    parameter int IW          = 16,
    parameter int AW          = 8,
    parameter int CW          = 8,
    parameter int TAIL_LO     = 4,
    parameter int TAIL_HI     = 15,
    parameter int RESUME_ADDR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tail_en,
    input  logic [CW-1:0] cfg_size,
    input  logic [CW-1:0] cfg_iter,
    input  logic          restart,
    output logic [AW-1:0] pm_addr,
    input  logic [IW-1:0] pm_data,
    output logic          iss_valid,
    output logic [AW-1:0] iss_addr,
    output logic [IW-1:0] iss_instr,
    output logic          init_strobe,
    output logic          halted
);
    import lfu_pkg::*;

    localparam logic [AW-1:0] RESUME_PC = AW'(RESUME_ADDR);

    lfu_state_e    state_q, state_d;
    logic [AW-1:0] pc_q;
    logic [IW-1:0] eff_word;
    logic          is_rep, is_init, is_stop, rep_sel;
    logic [AW-1:0] rep_end;
    logic          jump;
    logic [AW-1:0] target;
    logic          running;
    logic          resume;

    assign pm_addr = pc_q;
    assign running = (state_q == ST_RUN);
    assign resume  = (state_q == ST_HALT) && restart;
    assign halted  = (state_q == ST_HALT);

    lfu_decode #(.IW(IW), .AW(AW), .TAIL_LO(TAIL_LO), .TAIL_HI(TAIL_HI)) u_dec (
        .pc      (pc_q),
        .word    (pm_data),
        .tail_en (tail_en),
        .eff_word(eff_word),
        .is_rep  (is_rep),
        .is_init (is_init),
        .is_stop (is_stop),
        .rep_sel (rep_sel),
        .rep_end (rep_end)
    );

    lfu_loop #(.AW(AW), .CW(CW)) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (resume),
        .advance (running),
        .pc      (pc_q),
        .load    (is_rep),
        .sel     (rep_sel),
        .end_addr(rep_end),
        .cfg_size(cfg_size),
        .cfg_iter(cfg_iter),
        .jump    (jump),
        .target  (target)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (is_stop) state_d = ST_HALT;
            ST_HALT: if (restart) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q        <= '0;
            iss_valid   <= 1'b0;
            iss_addr    <= '0;
            iss_instr   <= '0;
            init_strobe <= 1'b0;
        end else begin
            iss_valid   <= 1'b0;
            init_strobe <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    iss_valid   <= 1'b1;
                    iss_addr    <= pc_q;
                    iss_instr   <= eff_word;
                    init_strobe <= is_init;
                    pc_q        <= jump ? target : pc_q + AW'(1);
                end
                ST_HALT: begin
                    if (restart) pc_q <= RESUME_PC;
                end
                default: pc_q <= pc_q;
            endcase
        end
    end
endmodule

// File: rtl/lfu_checker.sv
module lfu_checker #(
    parameter int IW          = 16,
    parameter int AW          = 8,
    parameter int TAIL_LO     = 4,
    parameter int TAIL_HI     = 15,
    parameter int RESUME_ADDR = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tail_en,
    input logic          iss_valid,
    input logic [AW-1:0] iss_addr,
    input logic [IW-1:0] iss_instr,
    input logic          init_strobe,
    input logic          halted
);
    localparam logic [AW-1:0] WLO = AW'(TAIL_LO);
    localparam logic [AW-1:0] WHI = AW'(TAIL_HI);
    localparam logic [AW-1:0] RPC = AW'(RESUME_ADDR);

    logic [3:0] opc;
    assign opc = iss_instr[IW-1 -: 4];

    assert_tail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !$past(tail_en) && iss_addr >= WLO && iss_addr <= WHI) |-> (iss_instr == '0));

    assert_init_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_strobe == (iss_valid && opc == 4'h2));

    assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && opc == 4'h3) |-> halted);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !iss_valid);

    assert_resume_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |=> (iss_valid && iss_addr == RPC));
endmodule

bind loop_fetch_unit lfu_checker #(
    .IW(IW), .AW(AW), .TAIL_LO(TAIL_LO), .TAIL_HI(TAIL_HI), .RESUME_ADDR(RESUME_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tail_en    (tail_en),
    .iss_valid  (iss_valid),
    .iss_addr   (iss_addr),
    .iss_instr  (iss_instr),
    .init_strobe(init_strobe),
    .halted     (halted)
);

// File: tb/sim_loop_fetch_unit.sv
module sim_loop_fetch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 16;
    localparam int AW = 8;
    localparam int CW = 8;

    typedef struct {
        int          addr;
        logic [15:0] instr;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tail_en = 1'b0;
    logic [CW-1:0] cfg_size = '0;
    logic [CW-1:0] cfg_iter = '0;
    logic          restart = 1'b0;
    logic [AW-1:0] pm_addr;
    logic [IW-1:0] pm_data;
    logic          iss_valid;
    logic [AW-1:0] iss_addr;
    logic [IW-1:0] iss_instr;
    logic          init_strobe;
    logic          halted;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t exp_q[$];
    logic prev_valid = 1'b0;
    logic prev_halted = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // program: 0 repeat(sel0,end 3), 2 init, 17 repeat(sel1,end 20), 21 stop
    function automatic logic [15:0] prog_word(input int a);
        case (a)
            0:       return 16'h1003;
            2:       return 16'h2000;
            17:      return 16'h1114;
            21:      return 16'h3000;
            default: return {8'hA0, 8'(a)};
        endcase
    endfunction

    assign pm_data = prog_word(int'(pm_addr));

    loop_fetch_unit u0 (
        .clk(clk), .rst_n(rst_n), .tail_en(tail_en), .cfg_size(cfg_size),
        .cfg_iter(cfg_iter), .restart(restart), .pm_addr(pm_addr), .pm_data(pm_data),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_instr(iss_instr),
        .init_strobe(init_strobe), .halted(halted)
    );

    task automatic push(input int a, input bit tail, input string tag);
        exp_t e;
        e.addr  = a;
        e.instr = (a >= 4 && a <= 15 && !tail) ? 16'h0000 : prog_word(a);
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_run(input int n0, input int n1, input bit tail,
                            input bit from_resume, input string tag0, input string tag1);
        int e0 = (n0 == 0) ? 1 : n0;
        int e1 = (n1 == 0) ? 1 : n1;
        if (!from_resume) begin
            push(0, tail, "R1");
            for (int p = 0; p < e0; p++)
                for (int a = 1; a <= 3; a++) push(a, tail, tag0);
            for (int a = 4; a <= 15; a++) push(a, tail, tail ? "R8" : "R7");
            push(16, tail, "R2");
        end else begin
            push(16, tail, "R11");
        end
        push(17, tail, "R2");
        for (int p = 0; p < e1; p++)
            for (int a = 18; a <= 20; a++) push(a, tail, tag1);
        push(21, tail, "R10");
    endtask

    task automatic check(input bit ok, input string msg, input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", msg, got, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (iss_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 issue with nothing expected, addr", int'(iss_addr), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(iss_addr) == e.addr, {e.tag, " issue address"}, int'(iss_addr), e.addr);
                    check(iss_instr == e.instr, {e.tag, " issue word"}, int'(iss_instr), int'(e.instr));
                    check(init_strobe == (e.instr[15:12] == 4'h2), "R9 init strobe",
                          int'(init_strobe), int'(e.instr[15:12] == 4'h2));
                end
            end else if (prev_valid && !prev_halted && exp_q.size() != 0) begin
                check(1'b0, "R6 idle cycle inside stream, valid", 0, 1);
            end
        end
        prev_valid  = iss_valid;
        prev_halted = halted;
    end

    task automatic start_run(input int sz, input int it, input bit tail,
                             input string tag0, input string tag1);
        @(negedge clk);
        rst_n    = 1'b0;
        restart  = 1'b0;
        cfg_size = CW'(sz);
        cfg_iter = CW'(it);
        tail_en  = tail;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(iss_valid == 1'b0, "R1 valid in reset", int'(iss_valid), 0);
        check(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
        push_run(sz, it, tail, 1'b0, tag0, tag1);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt();
        int n = 0;
        while (!(halted && exp_q.size() == 0) && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(halted == 1'b1, "R10 halted after stop", int'(halted), 1);
        check(exp_q.size() == 0, "R10 pending items at halt", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        check(halted == 1'b1 && iss_valid == 1'b0, "R10 stays halted", int'(iss_valid), 0);
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        // A: sel0 count 2, sel1 count 3, tail squashed; then resume
        start_run(2, 3, 1'b0, "R3", "R4");
        wait_halt();
        push_run(2, 3, 1'b0, 1'b1, "R3", "R4");
        pulse_restart();
        wait_halt();

        // B: zero size count gives one pass, tail kept
        start_run(0, 1, 1'b1, "R5", "R4");
        wait_halt();

        // C: zero iteration count, restart while running ignored (R11)
        start_run(3, 0, 1'b0, "R3", "R5");
        repeat (5) @(negedge clk);
        pulse_restart();
        wait_halt();
        push_run(3, 0, 1'b0, 1'b1, "R3", "R5");
        pulse_restart();
        wait_halt();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired, cycles %0d expected below %0d", cycles, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule